// File: doc/BRIEF.md
# Paged Register Address Decoder

This block sits behind a two-wire serial slave front end and turns each byte access into a storage region code and an offset within that region. The front end supplies the 7-bit device identifier, the byte address, read and write strobes, and the write data. The decoder holds one page register per transmitter channel. Byte addresses in the lower half always land in that channel's fixed lower region. Byte addresses in the upper half land in whichever page that channel's page register currently names.

The two channel identifiers each have their own lower region, their own lookup-table pages and their own page register. One configuration page is shared and reaches the same storage through either identifier. A third identifier opens a flat 256-byte nonvolatile array and ignores paging. A configuration input moves each channel's eight alarm and warning enable bytes from page 01h to page 05h. In that mode their old slots read as empty. Any access that lands on nothing raises the empty flag, and the surrounding data path then returns 00h for a read and drops a write. Storage, the serial protocol and password checks are outside this block.

Top module: `paged_reg_decoder`

## Requirements
- R1: With the channel A identifier 51h or the channel B identifier 59h, byte addresses 00h–7Fh map to that channel's lower region whatever the page register holds (region 2 for A, 3 for B), with offset equal to the byte address.
- R2: Each channel has its own page register, which resets to TSEL_POR (default 01h). A write strobe at byte address 7Fh through a channel identifier loads that channel's register from the write data, and the new value governs accesses from the next cycle on. The other channel's register does not change, and a write to 7Fh through the auxiliary identifier changes neither register.
- R3: Page 02h is shared. Byte addresses 80h–CFh through either channel map to region 5 with offset = address − 80h.
- R4: Page 02h addresses D0h–FFh are empty. Every empty access drives empty = 1, region 0 and offset 0, so a read returns 00h and a write is dropped.
- R5: In page 01h with the relocate input low, channel A addresses 80h–F7h map to region 4 (user array) with offset = address − 80h. Addresses F8h–FFh map to the channel's enable region (10 for A, 11 for B) with offset = address − F8h. Channel B addresses 80h–F7h are empty.
- R6: The auxiliary identifier 50h maps every byte address 00h–FFh to region 1 with offset equal to the address. It is never empty and is unaffected by any page register.
- R7: With the relocate input high, page 01h addresses F8h–FFh are empty. Page 05h addresses F8h–FFh then map to the channel's enable region (10 for A, 11 for B) with offset = address − F8h.
- R8: Page 05h is entirely empty while the relocate input is low. Its addresses 80h–F7h are empty in either mode.
- R9: Page 04h maps 80h–FFh to the channel's modulation table (6 for A, 7 for B), and page 06h maps them to the channel's bias table (8 for A, 9 for B), each with offset = address − 80h.
- R10: A page register value other than 01h, 02h, 04h, 05h or 06h makes every upper address of that channel empty.
- R11: hit is 1 only while a read or write strobe is high and the identifier is 50h, 51h or 59h. While hit is 0, empty is 0, region is 0 and offset is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 7 | Device identifier from the serial front end |
| byte_addr | input | 8 | Byte address within the device |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (used here only for the page register) |
| relocate | input | 1 | Move the enable bytes from page 01h to page 05h |
| hit | output | 1 | Access addresses a recognised identifier |
| empty | output | 1 | Access lands on an empty or reserved location |
| region | output | 4 | Storage region code (0 = none) |
| offset | output | 8 | Byte offset within the selected region |

## Verification
The bench goes after the page boundaries: the D0h edge of the shared page, the F7h/F8h split between user array and enable bytes, and the unlisted page values. A decoder that compared one bit too few would leak reserved space into a live region. It toggles the relocate input on both pages 01h and 05h, where a wrong polarity would expose the enable bytes twice or not at all. It loads each channel's page register separately and writes 7Fh through the auxiliary identifier. These cases catch a shared or cross-wired page register, which would send one channel's upper accesses into the other's tables. It also checks the power-on page and an unknown identifier, which must give no hit.

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder #(
  parameter logic [6:0] AUX_ID   = 7'h50,
  parameter logic [6:0] CHA_ID   = 7'h51,
  parameter logic [6:0] CHB_ID   = 7'h59,
  parameter logic [7:0] TSEL_POR = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_id,
  input  logic [7:0] byte_addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       relocate,
  output logic       hit,
  output logic       empty,
  output logic [3:0] region,
  output logic [7:0] offset
);

  localparam logic [3:0] RG_NONE  = 4'd0;
  localparam logic [3:0] RG_AUX   = 4'd1;
  localparam logic [3:0] RG_LOW_A = 4'd2;
  localparam logic [3:0] RG_LOW_B = 4'd3;
  localparam logic [3:0] RG_USER  = 4'd4;
  localparam logic [3:0] RG_SHARE = 4'd5;
  localparam logic [3:0] RG_MOD_A = 4'd6;
  localparam logic [3:0] RG_MOD_B = 4'd7;
  localparam logic [3:0] RG_BIA_A = 4'd8;
  localparam logic [3:0] RG_BIA_B = 4'd9;
  localparam logic [3:0] RG_EN_A  = 4'd10;
  localparam logic [3:0] RG_EN_B  = 4'd11;
  localparam logic [7:0] PAGE_REG = 8'h7F;
  localparam logic [7:0] SHR_END  = 8'hD0;

  logic [7:0] tsel_a, tsel_b, page;
  logic       is_aux, is_a, is_b, en_zone;
  logic [7:0] up_off, en_off;

  assign is_aux  = dev_id == AUX_ID;
  assign is_a    = dev_id == CHA_ID;
  assign is_b    = dev_id == CHB_ID;
  assign hit     = (rd_en | wr_en) & (is_aux | is_a | is_b);
  assign page    = is_b ? tsel_b : tsel_a;
  assign en_zone = byte_addr[7:3] == 5'h1F;
  assign up_off  = {1'b0, byte_addr[6:0]};
  assign en_off  = {5'd0, byte_addr[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_a <= TSEL_POR;
      tsel_b <= TSEL_POR;
    end else if (wr_en && byte_addr == PAGE_REG) begin
      if (is_a) tsel_a <= wr_data;
      if (is_b) tsel_b <= wr_data;
    end
  end

  logic [3:0] rg;
  logic [7:0] off;

  always_comb begin
    rg  = RG_NONE;
    off = byte_addr;
    if (is_aux) begin
      rg = RG_AUX;
    end else if (!byte_addr[7]) begin
      rg = is_a ? RG_LOW_A : RG_LOW_B;
    end else begin
      off = up_off;
      unique case (page)
        8'h01: begin
          if (en_zone) begin
            rg  = relocate ? RG_NONE : (is_a ? RG_EN_A : RG_EN_B);
            off = en_off;
          end else if (is_a) begin
            rg = RG_USER;
          end
        end
        8'h02: if (byte_addr < SHR_END) rg = RG_SHARE;
        8'h04: rg = is_a ? RG_MOD_A : RG_MOD_B;
        8'h05: begin
          if (en_zone && relocate) begin
            rg  = is_a ? RG_EN_A : RG_EN_B;
            off = en_off;
          end
        end
        8'h06: rg = is_a ? RG_BIA_A : RG_BIA_B;
        default: rg = RG_NONE;
      endcase
    end
  end

  assign empty  = hit && rg == RG_NONE;
  assign region = hit ? rg : RG_NONE;
  assign offset = (hit && rg != RG_NONE) ? off : 8'd0;

endmodule

// File: rtl/paged_reg_decoder_chk.sv
module paged_reg_decoder_chk #(
  parameter logic [6:0] AUX_ID = 7'h50,
  parameter logic [6:0] CHA_ID = 7'h51,
  parameter logic [6:0] CHB_ID = 7'h59
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] dev_id,
  input logic [7:0] byte_addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       hit,
  input logic       empty,
  input logic [3:0] region,
  input logic [7:0] offset,
  input logic [7:0] tsel_a,
  input logic [7:0] tsel_b
);

  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!empty && region == 4'd0 && offset == 8'd0)); // R11

  AST_EMPTY_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (hit && region == 4'd0 && offset == 8'd0)); // R4

  AST_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dev_id != AUX_ID && !byte_addr[7]) |->
      ((region == 4'd2 || region == 4'd3) && offset == byte_addr)); // R1

  AST_AUX_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dev_id == AUX_ID) |-> (!empty && region == 4'd1 && offset == byte_addr)); // R6

  AST_SHARED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    region == 4'd5 |-> (byte_addr >= 8'h80 && byte_addr < 8'hD0)); // R3

  AST_ENABLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd10 || region == 4'd11) |-> (byte_addr[7:3] == 5'h1F && offset < 8'd8)); // R5

  AST_PAGE_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dev_id == CHA_ID && byte_addr == 8'h7F) |=> tsel_a == $past(wr_data)); // R2

  AST_PAGE_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dev_id == CHB_ID && byte_addr == 8'h7F) |=> tsel_b == $past(wr_data)); // R2

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && byte_addr == 8'h7F && (dev_id == CHA_ID || dev_id == CHB_ID))
      |=> ($stable(tsel_a) && $stable(tsel_b))); // R2

endmodule

bind paged_reg_decoder paged_reg_decoder_chk #(
  .AUX_ID(AUX_ID), .CHA_ID(CHA_ID), .CHB_ID(CHB_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .byte_addr(byte_addr),
  .wr_en(wr_en), .wr_data(wr_data), .hit(hit), .empty(empty),
  .region(region), .offset(offset), .tsel_a(tsel_a), .tsel_b(tsel_b)
);

// File: tb/paged_reg_decoder_tb.sv
module paged_reg_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dev_id = 7'h00;
  logic [7:0] byte_addr = 8'h00;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       relocate = 1'b0;
  logic       hit, empty;
  logic [3:0] region;
  logic [7:0] offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  paged_reg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .byte_addr(byte_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .relocate(relocate),
    .hit(hit), .empty(empty), .region(region), .offset(offset)
  );

  localparam logic [6:0] AX = 7'h50, CA = 7'h51, CB = 7'h59;

  // fields: dev, page (FF = leave page alone), addr, relocate, hit, empty, region, offset, requirement
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {CA,    8'h01, 8'h10, 1'b0, 1'b1, 1'b0, 4'd2,  8'h10, 4'd1},  // R1
    {CB,    8'h06, 8'h7E, 1'b0, 1'b1, 1'b0, 4'd3,  8'h7E, 4'd1},  // R1
    {AX,    8'hFF, 8'hC3, 1'b0, 1'b1, 1'b0, 4'd1,  8'hC3, 4'd6},  // R6
    {AX,    8'hFF, 8'h05, 1'b1, 1'b1, 1'b0, 4'd1,  8'h05, 4'd6},  // R6
    {CA,    8'h02, 8'h85, 1'b0, 1'b1, 1'b0, 4'd5,  8'h05, 4'd3},  // R3
    {CB,    8'h02, 8'h85, 1'b0, 1'b1, 1'b0, 4'd5,  8'h05, 4'd3},  // R3
    {CB,    8'h02, 8'hCF, 1'b0, 1'b1, 1'b0, 4'd5,  8'h4F, 4'd3},  // R3
    {CA,    8'h02, 8'hD0, 1'b0, 1'b1, 1'b1, 4'd0,  8'h00, 4'd4},  // R4
    {CB,    8'h02, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd0,  8'h00, 4'd4},  // R4
    {CA,    8'h01, 8'h90, 1'b0, 1'b1, 1'b0, 4'd4,  8'h10, 4'd5},  // R5
    {CA,    8'h01, 8'hF7, 1'b0, 1'b1, 1'b0, 4'd4,  8'h77, 4'd5},  // R5
    {CA,    8'h01, 8'hF9, 1'b0, 1'b1, 1'b0, 4'd10, 8'h01, 4'd5},  // R5
    {CB,    8'h01, 8'hFB, 1'b0, 1'b1, 1'b0, 4'd11, 8'h03, 4'd5},  // R5
    {CB,    8'h01, 8'h90, 1'b0, 1'b1, 1'b1, 4'd0,  8'h00, 4'd5},  // R5
    {CA,    8'h01, 8'hF8, 1'b1, 1'b1, 1'b1, 4'd0,  8'h00, 4'd7},  // R7
    {CA,    8'h05, 8'hFF, 1'b1, 1'b1, 1'b0, 4'd10, 8'h07, 4'd7},  // R7
    {CB,    8'h05, 8'hFA, 1'b1, 1'b1, 1'b0, 4'd11, 8'h02, 4'd7},  // R7
    {CA,    8'h05, 8'hFA, 1'b0, 1'b1, 1'b1, 4'd0,  8'h00, 4'd8},  // R8
    {CA,    8'h05, 8'h90, 1'b1, 1'b1, 1'b1, 4'd0,  8'h00, 4'd8},  // R8
    {CA,    8'h04, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd6,  8'h20, 4'd9},  // R9
    {CB,    8'h04, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd7,  8'h20, 4'd9},  // R9
    {CA,    8'h06, 8'h80, 1'b0, 1'b1, 1'b0, 4'd8,  8'h00, 4'd9},  // R9
    {CB,    8'h06, 8'hC7, 1'b0, 1'b1, 1'b0, 4'd9,  8'h47, 4'd9},  // R9
    {CA,    8'h03, 8'h80, 1'b0, 1'b1, 1'b1, 4'd0,  8'h00, 4'd10}  // R10
  };

  task automatic set_page(input logic [6:0] d, input logic [7:0] v);
    @(negedge clk);
    dev_id = d; byte_addr = 8'h7F; wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [6:0] d, input logic [7:0] a, input logic rl, input logic rd,
                       input logic eh, input logic ee, input logic [3:0] er, input logic [7:0] eo,
                       input int rq);
    @(negedge clk);
    dev_id = d; byte_addr = a; relocate = rl; rd_en = rd; wr_en = 1'b0;
    #2;
    n_chk++;
    if (hit !== eh || empty !== ee || region !== er || offset !== eo) begin
      n_bad++;
      $display("FAIL R%0d dev=%h addr=%h: got hit=%b empty=%b region=%0d offset=%h, expected hit=%b empty=%b region=%0d offset=%h",
               rq, d, a, hit, empty, region, offset, eh, ee, er, eo);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: both pages start at the power-on value 01h
    probe(CA, 8'h90, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 8'h10, 2);
    probe(CB, 8'hFC, 1'b0, 1'b1, 1'b1, 1'b0, 4'd11, 8'h04, 2);
    // R11: no strobe, no hit
    probe(CA, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 11);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34:27] != 8'hFF) set_page(VEC[i][41:35], VEC[i][34:27]);
      probe(VEC[i][41:35], VEC[i][26:19], VEC[i][18], 1'b1, VEC[i][17], VEC[i][16],
            VEC[i][15:12], VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // R2: pages are per channel and the auxiliary device cannot touch them
    set_page(CA, 8'h04);
    set_page(CB, 8'h06);
    @(negedge clk);
    dev_id = AX; byte_addr = 8'h7F; wr_data = 8'h02; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    probe(CA, 8'h85, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6, 8'h05, 2);
    probe(CB, 8'hA0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9, 8'h20, 2);

    // R2: a page write takes effect on the very next access
    set_page(CA, 8'h02);
    probe(CA, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5, 8'h01, 2);

    // R4: a write strobe on an empty location is flagged and routed nowhere
    @(negedge clk);
    dev_id = CA; byte_addr = 8'hE0; wr_data = 8'h5A; wr_en = 1'b1; relocate = 1'b0;
    #2;
    n_chk++;
    if (hit !== 1'b1 || empty !== 1'b1 || region !== 4'd0) begin
      n_bad++;
      $display("FAIL R4 write to empty: got hit=%b empty=%b region=%0d, expected 1 1 0", hit, empty, region);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R10: page FFh leaves the upper half empty
    set_page(CB, 8'hFF);
    probe(CB, 8'hC0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 8'h00, 10);
    // R1: lower region still reachable with an unlisted page
    probe(CB, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'h00, 1);

    // R11: unknown identifiers give no hit
    probe(7'h52, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 11);
    probe(7'h58, 8'h90, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 11);

    // R2: reset restores the power-on page
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(CA, 8'hF8, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10, 8'h00, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule